// File: doc/BRIEF.md
# Carrier-Gap Downlink Command Encoder

This block sends a command to a low-frequency read/write tag by keying the reader's carrier field on and off. It first holds the field on so the tag can power up. It then opens a start gap. After that it plays out a command frame as a series of carrier pulses, each followed by a fixed field-off gap. The length of each pulse carries the data. Every duration is counted in carrier cycles, which arrive as a one-clock `carrier_tick` enable.

A start strobe captures the request: a two-bit scheme select, six command flags, a 32-bit password, 32-bit data and a 3-bit block address. The frame builder assembles the frame, left-aligned, into an 80-bit buffer. Four schemes share this builder and differ only in their prefix bits, their pulse-length table and an optional long reference pulse:

- fixed-bit (code 0),
- long-reference (code 1),
- leading-zero (code 2),
- two-bits-per-pulse (code 3).

A state machine walks the states IDLE, POWER (power-up hold), SGAP (start gap), LREF (long reference pulse), PULSE, GAP and DONE. Its transitions are:

- IDLE→POWER on an accepted start.
- POWER→SGAP when the power-up hold expires.
- SGAP→LREF in scheme 1, or SGAP→PULSE otherwise.
- LREF→GAP.
- PULSE→GAP.
- GAP→PULSE while frame bits remain, or GAP→DONE when none remain.
- DONE→IDLE.

Top module: `rfid_pulse_encoder`

## Requirements
- R1: Out of reset and whenever idle, `field_en`=1, `busy`=0 and `done`=0.
- R2: A `start` seen while idle is accepted. `busy` rises at the next clock. The field stays on for `POWERUP_CYC` ticks (default 625, i.e. 5 ms of 8 µs cycles), then goes off for 31 ticks (start gap).
- R3: In scheme 0 a '0' bit is 18 ticks on and a '1' bit is 50 ticks on, and every pulse is followed by 20 ticks off.
- R4: In scheme 2 the frame starts with one extra 0 bit. A '1' pulse is 40 ticks. Two 0 bits sit between the opcode and the password.
- R5: In scheme 1 a reference pulse of 154 ticks on plus a 20-tick gap follows the start gap. The frame bits then follow with scheme-0 timing and no prefix.
- R6: In scheme 3 the frame starts with two 0 bits and is sent as bit pairs, MSB first. The pulse lengths are 18 ticks for pair 00, 34 for 01, 50 for 10 and 66 for 11. Two 0 bits sit between the opcode and the password.
- R7: The opcode follows the prefix. It is 00 when the reset flag is set, and the frame then ends. It is 01 when the test flag is set. Otherwise it is 1 followed by the page flag.
- R8: With the password flag set, the 32-bit password follows the opcode (and any fixed zeros), MSB first.
- R9: After that come a lock bit of 0, then the 32 data bits MSB first (dropped when the read flag is set), then the 3 address bits MSB first. The lock bit and the address are dropped when the register-read flag is set.
- R10: When the last gap ends, `field_en` returns to 1. `done` is 1 for exactly that one clock, and `busy` falls on the next clock.
- R11: A `start` while busy is ignored, and the frame in flight is unchanged.
- R12: Durations advance only on clocks with `carrier_tick`=1, so interval lengths in ticks do not depend on how sparse the ticks are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| carrier_tick | input | 1 | One-clock enable per carrier cycle |
| start | input | 1 | Command request strobe |
| mode | input | 2 | Downlink scheme: 0 fixed, 1 long reference, 2 leading zero, 3 pairs |
| flag_pwd | input | 1 | Include the password |
| flag_page | input | 1 | Page bit of the opcode |
| flag_test | input | 1 | Test opcode 01 |
| flag_reset | input | 1 | Reset opcode 00, frame ends after it |
| flag_read | input | 1 | Read command: omit the data bits |
| flag_regread | input | 1 | Register read: omit the lock bit and the address |
| password | input | 32 | Password value |
| wdata | input | 32 | Data value |
| block_addr | input | 3 | Block address |
| field_en | output | 1 | Carrier on (1) or off (0) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
Each field interval is due a fixed number of carrier ticks after the state that opened it. The bench therefore samples `field_en` on the falling clock edge and counts only the ticks it drives while the level holds. It compares the resulting run list against a list built from the requirements. That comparison is exact even with sparse ticks. The reference list covers the power-up hold, the start gap, the optional reference pulse and every pulse and gap. `done` must appear in the very sample where the field rises after the last gap, and `busy` must be low one clock later. These two are checked at those exact samples.

// File: rtl/rfid_pulse_pkg.sv
package rfid_pulse_pkg;

    localparam int FRAME_W = 80;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        MODE_FIXED = 2'd0,
        MODE_LREF  = 2'd1,
        MODE_LZERO = 2'd2,
        MODE_QUAD  = 2'd3
    } dl_mode_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_POWER,
        S_SGAP,
        S_LREF,
        S_PULSE,
        S_GAP,
        S_DONE
    } enc_state_t;

    typedef struct packed {
        logic pwd;
        logic page;
        logic test;
        logic rst;
        logic rd;
        logic regrd;
    } cmd_flags_t;

endpackage

// File: rtl/rfid_frame_builder.sv
module rfid_frame_builder
    import rfid_pulse_pkg::*;
(
    input  dl_mode_t                 mode,
    input  cmd_flags_t               flags,
    input  logic [31:0]              password,
    input  logic [31:0]              wdata,
    input  logic [2:0]               block_addr,
    output logic [FRAME_W-1:0]       frame,
    output logic [LEN_W-1:0]         frame_len
);
    logic [FRAME_W-1:0] acc;
    logic [LEN_W-1:0]   n;
    logic               zero_pad;

    assign zero_pad = (mode == MODE_LZERO) || (mode == MODE_QUAD);

    always_comb begin
        acc = '0;
        n   = '0;
        // scheme-dependent prefix
        if (mode == MODE_LZERO) begin
            acc = {acc[FRAME_W-2:0], 1'b0};
            n   = n + LEN_W'(1);
        end else if (mode == MODE_QUAD) begin
            acc = {acc[FRAME_W-3:0], 2'b00};
            n   = n + LEN_W'(2);
        end
        if (flags.rst) begin
            acc = {acc[FRAME_W-3:0], 2'b00};
            n   = n + LEN_W'(2);
        end else begin
            acc = {acc[FRAME_W-3:0], (flags.test ? 2'b01 : {1'b1, flags.page})};
            n   = n + LEN_W'(2);
            if (flags.pwd) begin
                if (zero_pad) begin
                    acc = {acc[FRAME_W-3:0], 2'b00};
                    n   = n + LEN_W'(2);
                end
                acc = {acc[FRAME_W-33:0], password};
                n   = n + LEN_W'(32);
            end
            if (!flags.regrd) begin
                acc = {acc[FRAME_W-2:0], 1'b0};
                n   = n + LEN_W'(1);
            end
            if (!flags.rd) begin
                acc = {acc[FRAME_W-33:0], wdata};
                n   = n + LEN_W'(32);
            end
            if (!flags.regrd) begin
                acc = {acc[FRAME_W-4:0], block_addr};
                n   = n + LEN_W'(3);
            end
        end
        frame     = acc << (LEN_W'(FRAME_W) - n);
        frame_len = n;
    end
endmodule

// File: rtl/rfid_tick_timer.sv
module rfid_tick_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign expire = tick && (cnt == CNT_W'(1));
endmodule

// File: rtl/rfid_pulse_encoder.sv
module rfid_pulse_encoder
    import rfid_pulse_pkg::*;
#(
    parameter int POWERUP_CYC = 625,
    parameter int T_SGAP      = 31,
    parameter int T_GAP       = 20,
    parameter int T_ZERO      = 18,
    parameter int T_ONE       = 50,
    parameter int T_LZ_ONE    = 40,
    parameter int T_P01       = 34,
    parameter int T_P10       = 50,
    parameter int T_P11       = 66,
    parameter int T_LREF_ADD  = 136
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        carrier_tick,
    input  logic        start,
    input  logic [1:0]  mode,
    input  logic        flag_pwd,
    input  logic        flag_page,
    input  logic        flag_test,
    input  logic        flag_reset,
    input  logic        flag_read,
    input  logic        flag_regread,
    input  logic [31:0] password,
    input  logic [31:0] wdata,
    input  logic [2:0]  block_addr,
    output logic        field_en,
    output logic        busy,
    output logic        done
);
    localparam int T_LREF  = T_ZERO + T_LREF_ADD;
    localparam int T_MAX   = (POWERUP_CYC > T_LREF) ? POWERUP_CYC : T_LREF;
    localparam int CNT_W   = $clog2(T_MAX + 1);

    enc_state_t          state, nstate;
    dl_mode_t            mode_q;
    logic [FRAME_W-1:0]  frame_q, fb_frame;
    logic [LEN_W-1:0]    rem_q, fb_len;
    logic                tload, expire, shift_en;
    logic [CNT_W-1:0]    tval, sym_dur;
    cmd_flags_t          flags;

    assign flags = '{pwd: flag_pwd, page: flag_page, test: flag_test,
                     rst: flag_reset, rd: flag_read, regrd: flag_regread};

    rfid_frame_builder u_build (
        .mode       (dl_mode_t'(mode)),
        .flags      (flags),
        .password   (password),
        .wdata      (wdata),
        .block_addr (block_addr),
        .frame      (fb_frame),
        .frame_len  (fb_len)
    );

    rfid_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (carrier_tick),
        .load     (tload),
        .load_val (tval),
        .expire   (expire)
    );

    // pulse length of the symbol at the head of the frame
    always_comb begin
        unique case (mode_q)
            MODE_QUAD: begin
                unique case (frame_q[FRAME_W-1 -: 2])
                    2'b00:   sym_dur = CNT_W'(T_ZERO);
                    2'b01:   sym_dur = CNT_W'(T_P01);
                    2'b10:   sym_dur = CNT_W'(T_P10);
                    default: sym_dur = CNT_W'(T_P11);
                endcase
            end
            MODE_LZERO: sym_dur = frame_q[FRAME_W-1] ? CNT_W'(T_LZ_ONE) : CNT_W'(T_ZERO);
            default:    sym_dur = frame_q[FRAME_W-1] ? CNT_W'(T_ONE)    : CNT_W'(T_ZERO);
        endcase
    end

    // next-state and timer control
    always_comb begin
        nstate   = state;
        tload    = 1'b0;
        tval     = '0;
        shift_en = 1'b0;
        unique case (state)
            S_IDLE: if (start) begin
                nstate = S_POWER; tload = 1'b1; tval = CNT_W'(POWERUP_CYC);
            end
            S_POWER: if (expire) begin
                nstate = S_SGAP; tload = 1'b1; tval = CNT_W'(T_SGAP);
            end
            S_SGAP: if (expire) begin
                tload = 1'b1;
                if (mode_q == MODE_LREF) begin
                    nstate = S_LREF; tval = CNT_W'(T_LREF);
                end else begin
                    nstate = S_PULSE; tval = sym_dur;
                end
            end
            S_LREF: if (expire) begin
                nstate = S_GAP; tload = 1'b1; tval = CNT_W'(T_GAP);
            end
            S_PULSE: if (expire) begin
                nstate = S_GAP; tload = 1'b1; tval = CNT_W'(T_GAP); shift_en = 1'b1;
            end
            S_GAP: if (expire) begin
                if (rem_q == '0) begin
                    nstate = S_DONE;
                end else begin
                    nstate = S_PULSE; tload = 1'b1; tval = sym_dur;
                end
            end
            S_DONE:  nstate = S_IDLE;
            default: nstate = S_IDLE;
        endcase
    end

    // state and frame registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            mode_q  <= MODE_FIXED;
            frame_q <= '0;
            rem_q   <= '0;
        end else begin
            state <= nstate;
            if (state == S_IDLE && start) begin
                mode_q  <= dl_mode_t'(mode);
                frame_q <= fb_frame;
                rem_q   <= fb_len;
            end else if (shift_en) begin
                if (mode_q == MODE_QUAD) begin
                    frame_q <= frame_q << 2;
                    rem_q   <= rem_q - LEN_W'(2);
                end else begin
                    frame_q <= frame_q << 1;
                    rem_q   <= rem_q - LEN_W'(1);
                end
            end
        end
    end

    // Moore outputs
    always_comb begin
        field_en = !(state == S_SGAP || state == S_GAP);
        busy     = (state != S_IDLE);
        done     = (state == S_DONE);
    end
endmodule

// File: rtl/rfid_pulse_encoder_chk.sv
module rfid_pulse_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic field_en,
    input logic busy,
    input logic done
);
    AST_IDLE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (field_en && !done)); // R1
    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R2
    AST_POWER_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (field_en && !done)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (field_en && busy)); // R10
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done)); // R10
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R11
endmodule

bind rfid_pulse_encoder rfid_pulse_encoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .field_en (field_en),
    .busy     (busy),
    .done     (done)
);

// File: tb/rfid_pulse_encoder_test.sv
module rfid_pulse_encoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int PWR        = 50;
    localparam int NVEC       = 10;
    localparam int MAXR       = 256;

    typedef struct packed {
        logic [1:0]  mode;
        logic        pwd, page, test, rst, rd, rr;
        logic [31:0] pw;
        logic [31:0] dat;
        logic [2:0]  adr;
        logic [7:0]  npulse;
    } vec_t;

    // npulse: frame pulses by hand (excludes power-up and long reference)
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'hA5C3_0F81, 3'd1, 8'd38},
        '{2'd0, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h8000_0001, 32'h1234_5678, 3'd6, 8'd70},
        '{2'd2, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 32'h0, 32'hFFFF_FFFF, 3'd5, 8'd7},
        '{2'd2, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'hDEAD_BEEF, 32'hF0F0_0F0F, 3'd7, 8'd73},
        '{2'd3, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h1B1B_E4E4, 32'h3C96_69C3, 3'd3, 8'd37},
        '{2'd3, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b1, 32'h0, 32'h0, 3'd0, 8'd2},
        '{2'd1, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 32'h0, 32'h0000_FFFF, 3'd2, 8'd38},
        '{2'd0, 1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd7, 8'd2},
        '{2'd3, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 32'h0, 32'h0, 3'd0, 8'd2},
        '{2'd1, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 32'hC001_0A55, 32'h0, 3'd4, 8'd34}
    };

    logic clk = 1'b0, rst_n = 1'b0, carrier_tick = 1'b0, start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic flag_pwd = 0, flag_page = 0, flag_test = 0, flag_reset = 0, flag_read = 0, flag_regread = 0;
    logic [31:0] password = '0, wdata = '0;
    logic [2:0] block_addr = '0;
    logic field_en, busy, done;

    int tests = 0, fails = 0;
    int got_runs [MAXR];
    int exp_runs [MAXR];
    int got_n, exp_n;
    bit done_ok, busy_ok;

    always #(CLK_PERIOD/2) clk = ~clk;

    rfid_pulse_encoder #(.POWERUP_CYC(PWR)) uut (
        .clk(clk), .rst_n(rst_n), .carrier_tick(carrier_tick), .start(start),
        .mode(mode), .flag_pwd(flag_pwd), .flag_page(flag_page), .flag_test(flag_test),
        .flag_reset(flag_reset), .flag_read(flag_read), .flag_regread(flag_regread),
        .password(password), .wdata(wdata), .block_addr(block_addr),
        .field_en(field_en), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic string tag_of(input logic [1:0] m);
        case (m)
            2'd1:    return "R5";
            2'd2:    return "R4";
            2'd3:    return "R6";
            default: return "R3";
        endcase
    endfunction

    // expected run list from the requirements
    task automatic build_expected(input vec_t v);
        bit bits [80];
        int nb = 0;
        exp_n = 0;
        if (v.mode == 2'd2) bits[nb++] = 0;
        if (v.mode == 2'd3) begin bits[nb++] = 0; bits[nb++] = 0; end
        if (v.rst) begin
            bits[nb++] = 0; bits[nb++] = 0;
        end else begin
            bits[nb++] = v.test ? 1'b0 : 1'b1;
            bits[nb++] = v.test ? 1'b1 : v.page;
            if (v.pwd) begin
                if (v.mode >= 2'd2) begin bits[nb++] = 0; bits[nb++] = 0; end
                for (int i = 31; i >= 0; i--) bits[nb++] = v.pw[i];
            end
            if (!v.rr) bits[nb++] = 0;
            if (!v.rd) for (int i = 31; i >= 0; i--) bits[nb++] = v.dat[i];
            if (!v.rr) for (int i = 2; i >= 0; i--) bits[nb++] = v.adr[i];
        end
        exp_runs[exp_n++] = PWR;
        exp_runs[exp_n++] = 31;
        if (v.mode == 2'd1) begin
            exp_runs[exp_n++] = 154;
            exp_runs[exp_n++] = 20;
        end
        if (v.mode == 2'd3) begin
            for (int i = 0; i + 1 < nb; i += 2) begin
                exp_runs[exp_n++] = 18 + 16 * (2 * int'(bits[i]) + int'(bits[i+1]));
                exp_runs[exp_n++] = 20;
            end
        end else begin
            for (int i = 0; i < nb; i++) begin
                exp_runs[exp_n++] = bits[i] ? ((v.mode == 2'd2) ? 40 : 50) : 18;
                exp_runs[exp_n++] = 20;
            end
        end
    endtask

    // run one command, record field runs in ticks
    task automatic run_cmd(input vec_t v, input int tper, input bit inject);
        bit cur;
        int cnt = 0, iter = 0;
        bit rose;
        got_n = 0; done_ok = 0; busy_ok = 0;
        @(negedge clk);
        mode = v.mode; flag_pwd = v.pwd; flag_page = v.page; flag_test = v.test;
        flag_reset = v.rst; flag_read = v.rd; flag_regread = v.rr;
        password = v.pw; wdata = v.dat; block_addr = v.adr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cur = field_en;
        forever begin
            rose = 0;
            if (field_en != cur) begin
                if (got_n < MAXR) got_runs[got_n] = cnt;
                got_n++;
                rose = field_en;
                cur = field_en;
                cnt = 0;
            end
            if (done) begin
                done_ok = rose;
                break;
            end
            if (iter > 60000) begin
                check(0, "watchdog R10", iter, 0);
                break;
            end
            if (inject && iter == 300) begin
                start = 1'b1; mode = ~v.mode; wdata = ~v.dat; flag_reset = ~v.rst;
            end else begin
                start = 1'b0;
            end
            carrier_tick = ((iter % tper) == 0);
            if (carrier_tick) cnt++;
            iter++;
            @(negedge clk);
        end
        carrier_tick = 1'b1;
        start = 1'b0;
        @(negedge clk);
        busy_ok = !busy && !done && field_en;
    endtask

    task automatic compare_runs(input string req);
        int first_bad = -1;
        if (got_n != exp_n) begin
            check(0, {req, " run count"}, got_n, exp_n);
            return;
        end
        for (int i = 0; i < exp_n; i++)
            if (first_bad < 0 && got_runs[i] != exp_runs[i]) first_bad = i;
        if (first_bad >= 0)
            check(0, $sformatf("%s run %0d", req, first_bad), got_runs[first_bad], exp_runs[first_bad]);
        else
            check(1, req, 0, 0);
    endtask

    initial begin
        carrier_tick = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(field_en === 1'b1, "R1 field_en in reset", field_en, 1);
        check(busy === 1'b0, "R1 busy in reset", busy, 0);
        check(done === 1'b0, "R1 done in reset", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(field_en === 1'b1 && busy === 1'b0, "R1 idle after reset", busy, 0);

        // vector table
        for (int k = 0; k < NVEC; k++) begin
            int pulses;
            build_expected(VECS[k]);
            run_cmd(VECS[k], 1, 0);
            compare_runs($sformatf("%s R2 R7 R8 R9 vec%0d", tag_of(VECS[k].mode), k));
            pulses = (got_n - 2) / 2 - ((VECS[k].mode == 2'd1) ? 1 : 0);
            check(pulses == int'(VECS[k].npulse), $sformatf("%s R7 R9 pulse count vec%0d", tag_of(VECS[k].mode), k), pulses, VECS[k].npulse);
            check(done_ok, $sformatf("R10 done with field rise vec%0d", k), done_ok, 1);
            check(busy_ok, $sformatf("R10 busy low after done vec%0d", k), busy_ok, 1);
        end

        // R11: start while busy is ignored
        build_expected(VECS[4]);
        run_cmd(VECS[4], 1, 1);
        compare_runs("R11 start while busy");

        // R12: sparse carrier ticks
        build_expected(VECS[3]);
        run_cmd(VECS[3], 3, 0);
        compare_runs("R12 sparse ticks");
        check(done_ok, "R12 R10 done with sparse ticks", done_ok, 1);

        // R2: no start means no activity
        repeat (20) @(negedge clk);
        check(field_en === 1'b1 && busy === 1'b0, "R2 R1 stays idle without start", busy, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule